// File: doc/BRIEF.md
# Hierarchical Tile Depth Test

This block decides the fate of one incoming 4x4 pixel tile against a coarse depth buffer. The coarse buffer keeps a nearest and a farthest 16-bit depth for every tile. Smaller depth values are nearer. The block compares the incoming tile's depth bounds with the stored bounds first. When the comparison settles the outcome, the whole tile is discarded or written in one cycle and no per-pixel work runs. Only when the two ranges overlap does the block compare every pixel. It does this one row of four pixels per cycle, builds a 16-bit write mask and derives new stored bounds from the surviving depths.

A producer offers a tile with `in_valid` and the block takes it when `in_ready` is high. The producer supplies both bound pairs on every offer. It also supplies the sixteen incoming depths and the sixteen stored depths, which are used only when a per-pixel pass is needed. The result appears as a one-cycle `out_valid` pulse. The decision, mask and updated bounds stay on the outputs until the next result. Pixel `p` (row `p/4`, column `p%4`) occupies bits `[16p+15:16p]` of each depth bus and bit `p` of the mask.

Top module: `hz_tile_test`

## Requirements
- R1: When the incoming minimum is greater than the stored maximum, the tile is rejected. The result shows decision 2'b00, mask 16'h0000 and the stored bounds unchanged, with `out_valid` high in the cycle after the handshake.
- R2: When the incoming maximum is less than the stored minimum, the whole tile is accepted. The result shows decision 2'b01, mask 16'hFFFF and the incoming bounds as the new bounds, with `out_valid` high in the cycle after the handshake.
- R3: When both the reject and the accept conditions hold (a malformed tile), reject wins.
- R4: Any other case, including equal boundary values, selects the per-pixel path with decision 2'b10.
- R5: On the per-pixel path, pixel `p` passes only when its incoming depth is strictly less than its stored depth. A passing pixel sets mask bit `p`.
- R6: A per-pixel result appears four cycles after the handshake, one cycle per row. `in_ready` stays low from the handshake until the result is out.
- R7: After a per-pixel pass, the new bounds are the minimum and maximum of the resulting depths: the incoming depth where a pixel passes and the stored depth where it does not.
- R8: During reset and right after it, `in_ready` is 1, `out_valid` is 0, the decision is 2'b00 and the mask is zero.
- R9: During a per-pixel pass, changes on the depth and bound inputs and a raised `in_valid` are ignored. The result uses the values captured at the handshake.
- R10: `out_valid` is high for one cycle per accepted tile. The decision, mask and bounds hold their values while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Block can take a tile |
| tile_zmin | input | 16 | Nearest depth of incoming tile |
| tile_zmax | input | 16 | Farthest depth of incoming tile |
| buf_zmin | input | 16 | Stored nearest depth |
| buf_zmax | input | 16 | Stored farthest depth |
| new_depth | input | 256 | Sixteen incoming pixel depths |
| old_depth | input | 256 | Sixteen stored pixel depths |
| out_valid | output | 1 | Result pulse |
| out_decision | output | 2 | 00 reject, 01 accept all, 10 per pixel |
| out_mask | output | 16 | Per-pixel write mask |
| out_zmin | output | 16 | Updated stored nearest depth |
| out_zmax | output | 16 | Updated stored farthest depth |

## Verification
The bench targets boundary equality: a tile whose minimum equals the stored maximum must take the per-pixel path. A design using `>=` would reject it wrongly. Equal pixel depths must not pass, so a `<=` compare would show up as a full mask. A malformed tile with both conditions true must be rejected, which catches a swapped priority. The bench also changes the inputs during a per-pixel pass. A design that failed to capture the depths would produce a different mask or different bounds, and one that raised `in_ready` early would start a stray result.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int HZ_DW  = 16;
    localparam int HZ_DIM = 4;

    typedef enum logic [1:0] {
        HZ_REJECT = 2'b00,
        HZ_ACCEPT = 2'b01,
        HZ_PIXEL  = 2'b10
    } hz_dec_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RES  = 1'b1
    } hz_state_e;
endpackage

// File: rtl/hz_classify.sv
module hz_classify
    import hz_pkg::*;
#(
    parameter int DW = HZ_DW
) (
    input  logic [DW-1:0] tile_lo,
    input  logic [DW-1:0] tile_hi,
    input  logic [DW-1:0] ref_lo,
    input  logic [DW-1:0] ref_hi,
    output hz_dec_e       dec
);
    always_comb begin
        if (tile_lo > ref_hi)      dec = HZ_REJECT;   // wholly behind: wins on malformed input
        else if (tile_hi < ref_lo) dec = HZ_ACCEPT;   // wholly in front
        else                       dec = HZ_PIXEL;
    end
endmodule

// File: rtl/hz_row_lanes.sv
module hz_row_lanes #(
    parameter int DW    = 16,
    parameter int LANES = 4
) (
    input  logic [LANES*DW-1:0] cand,
    input  logic [LANES*DW-1:0] held,
    output logic [LANES-1:0]    pass,
    output logic [DW-1:0]       res_min,
    output logic [DW-1:0]       res_max
);
    logic [DW-1:0] res [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] c_w, h_w;
        assign c_w     = cand[g*DW +: DW];
        assign h_w     = held[g*DW +: DW];
        assign pass[g] = (c_w < h_w);
        assign res[g]  = pass[g] ? c_w : h_w;
    end

    always_comb begin
        res_min = res[0];
        res_max = res[0];
        for (int i = 1; i < LANES; i++) begin
            if (res[i] < res_min) res_min = res[i];
            if (res[i] > res_max) res_max = res[i];
        end
    end
endmodule

// File: rtl/hz_tile_test.sv
module hz_tile_test
    import hz_pkg::*;
#(
    parameter int DW  = HZ_DW,
    parameter int DIM = HZ_DIM
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DW-1:0]            tile_zmin,
    input  logic [DW-1:0]            tile_zmax,
    input  logic [DW-1:0]            buf_zmin,
    input  logic [DW-1:0]            buf_zmax,
    input  logic [DIM*DIM*DW-1:0]    new_depth,
    input  logic [DIM*DIM*DW-1:0]    old_depth,
    output logic                     out_valid,
    output logic [1:0]               out_decision,
    output logic [DIM*DIM-1:0]       out_mask,
    output logic [DW-1:0]            out_zmin,
    output logic [DW-1:0]            out_zmax
);
    localparam int NPIX  = DIM * DIM;
    localparam int RW    = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int ROWB  = DIM * DW;
    localparam logic [RW-1:0] LAST_ROW = RW'(DIM - 1);

    typedef struct packed {
        hz_state_e             st;
        logic [RW-1:0]         row;
        logic [NPIX*DW-1:0]    nd;
        logic [NPIX*DW-1:0]    od;
        logic [NPIX-1:0]       acc_mask;
        logic [DW-1:0]         acc_min;
        logic [DW-1:0]         acc_max;
        logic                  valid;
        hz_dec_e               dec;
        logic [NPIX-1:0]       mask;
        logic [DW-1:0]         zmin;
        logic [DW-1:0]         zmax;
    } hz_regs_t;

    hz_regs_t r_q, r_d;

    hz_dec_e       cls_dec;
    logic [DIM-1:0] row_pass;
    logic [DW-1:0]  row_min, row_max;

    hz_classify #(.DW(DW)) u_cls (
        .tile_lo (tile_zmin),
        .tile_hi (tile_zmax),
        .ref_lo  (buf_zmin),
        .ref_hi  (buf_zmax),
        .dec     (cls_dec)
    );

    hz_row_lanes #(.DW(DW), .LANES(DIM)) u_row (
        .cand    (r_q.nd[int'(r_q.row)*ROWB +: ROWB]),
        .held    (r_q.od[int'(r_q.row)*ROWB +: ROWB]),
        .pass    (row_pass),
        .res_min (row_min),
        .res_max (row_max)
    );

    assign in_ready = (r_q.st == ST_IDLE);

    always_comb begin
        logic [NPIX-1:0] mask_n;
        logic [DW-1:0]   min_n, max_n;
        r_d       = r_q;
        r_d.valid = 1'b0;
        mask_n = r_q.acc_mask | (NPIX'(row_pass) << (int'(r_q.row) * DIM));
        min_n  = (row_min < r_q.acc_min) ? row_min : r_q.acc_min;
        max_n  = (row_max > r_q.acc_max) ? row_max : r_q.acc_max;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    unique case (cls_dec)
                        HZ_REJECT: begin
                            r_d.valid = 1'b1;
                            r_d.dec   = HZ_REJECT;
                            r_d.mask  = '0;
                            r_d.zmin  = buf_zmin;
                            r_d.zmax  = buf_zmax;
                        end
                        HZ_ACCEPT: begin
                            r_d.valid = 1'b1;
                            r_d.dec   = HZ_ACCEPT;
                            r_d.mask  = '1;
                            r_d.zmin  = tile_zmin;
                            r_d.zmax  = tile_zmax;
                        end
                        default: begin
                            r_d.st       = ST_RES;
                            r_d.row      = '0;
                            r_d.nd       = new_depth;
                            r_d.od       = old_depth;
                            r_d.acc_mask = '0;
                            r_d.acc_min  = '1;
                            r_d.acc_max  = '0;
                        end
                    endcase
                end
            end
            ST_RES: begin
                r_d.acc_mask = mask_n;
                r_d.acc_min  = min_n;
                r_d.acc_max  = max_n;
                r_d.row      = r_q.row + RW'(1);
                if (r_q.row == LAST_ROW) begin
                    r_d.st    = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.dec   = HZ_PIXEL;
                    r_d.mask  = mask_n;
                    r_d.zmin  = min_n;
                    r_d.zmax  = max_n;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.dec   <= HZ_REJECT;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid    = r_q.valid;
    assign out_decision = r_q.dec;
    assign out_mask     = r_q.mask;
    assign out_zmin     = r_q.zmin;
    assign out_zmax     = r_q.zmax;

    AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_decision == 2'b00 |-> out_mask == '0); // R1
    AST_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_decision == 2'b01 |-> out_mask == '1); // R2
    AST_REJECT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && tile_zmin > buf_zmax |=> out_valid && out_decision == 2'b00); // R3
    AST_PIXEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cls_dec == HZ_PIXEL |=> !in_ready && !out_valid); // R6
    AST_BOUNDS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_decision == 2'b10 |-> out_zmin <= out_zmax); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_mask) && $stable(out_decision)); // R10
endmodule

// File: tb/hz_tile_test_tb.sv
module hz_tile_test_tb;
    localparam int DW = 16;
    localparam int NP = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [DW-1:0]   tile_zmin, tile_zmax, buf_zmin, buf_zmax;
    logic [NP*DW-1:0] new_depth, old_depth;
    logic            out_valid;
    logic [1:0]      out_decision;
    logic [NP-1:0]   out_mask;
    logic [DW-1:0]   out_zmin, out_zmax;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hz_tile_test u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .tile_zmin(tile_zmin), .tile_zmax(tile_zmax),
        .buf_zmin(buf_zmin), .buf_zmax(buf_zmax),
        .new_depth(new_depth), .old_depth(old_depth),
        .out_valid(out_valid), .out_decision(out_decision), .out_mask(out_mask),
        .out_zmin(out_zmin), .out_zmax(out_zmax)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one tile, derive expectations from the requirements, check the result.
    task automatic run_tile(input string tag, input logic [DW-1:0] tmin, tmax, bmin, bmax,
                            input logic [NP*DW-1:0] nd, od, input bit disturb);
        logic [1:0]    e_dec;
        logic [NP-1:0] e_mask;
        logic [DW-1:0] e_min, e_max;
        int            e_lat, lat;
        if (tmin > bmax) begin
            e_dec = 2'b00; e_mask = '0; e_min = bmin; e_max = bmax; e_lat = 0;
        end else if (tmax < bmin) begin
            e_dec = 2'b01; e_mask = '1; e_min = tmin; e_max = tmax; e_lat = 0;
        end else begin
            e_dec = 2'b10; e_mask = '0; e_min = '1; e_max = '0; e_lat = 4;
            for (int p = 0; p < NP; p++) begin
                logic [DW-1:0] n, o, rv;
                n = nd[p*DW +: DW]; o = od[p*DW +: DW];
                e_mask[p] = (n < o);
                rv = e_mask[p] ? n : o;
                if (rv < e_min) e_min = rv;
                if (rv > e_max) e_max = rv;
            end
        end
        @(negedge clk);
        tile_zmin = tmin; tile_zmax = tmax; buf_zmin = bmin; buf_zmax = bmax;
        new_depth = nd; old_depth = od; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            tile_zmin = 16'hFFF0; tile_zmax = 16'hFFFF; buf_zmin = 0; buf_zmax = 1;
            new_depth = '0; old_depth = '1;
        end else begin
            in_valid = 1'b0;
        end
        if (e_lat != 0) chk({tag, " R6 ready low"}, 64'(in_ready), 64'd0);
        lat = 0;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        chk({tag, " R6 latency"}, 64'(lat), 64'(e_lat));
        chk({tag, " R4 decision"}, 64'(out_decision), 64'(e_dec));
        chk({tag, " R5 mask"}, 64'(out_mask), 64'(e_mask));
        chk({tag, " R7 zmin"}, 64'(out_zmin), 64'(e_min));
        chk({tag, " R7 zmax"}, 64'(out_zmax), 64'(e_max));
    endtask

    function automatic logic [NP*DW-1:0] ramp(input int base, input int step);
        logic [NP*DW-1:0] v;
        for (int p = 0; p < NP; p++) v[p*DW +: DW] = DW'(base + p * step);
        return v;
    endfunction

    task automatic t_reset();
        chk("R8 ready", 64'(in_ready), 64'd1);
        chk("R8 valid", 64'(out_valid), 64'd0);
        chk("R8 decision", 64'(out_decision), 64'd0);
        chk("R8 mask", 64'(out_mask), 64'd0);
    endtask

    task automatic t_reject();
        run_tile("R1 reject", 500, 600, 100, 400, ramp(500, 5), ramp(100, 10), 1'b0);
    endtask

    task automatic t_accept();
        run_tile("R2 accept", 10, 50, 100, 400, ramp(10, 2), ramp(100, 10), 1'b0);
    endtask

    task automatic t_priority();
        run_tile("R3 malformed", 900, 5, 100, 400, ramp(5, 50), ramp(100, 10), 1'b0);
    endtask

    task automatic t_edge();
        run_tile("R4 equal edge", 400, 450, 100, 400, ramp(400, 3), ramp(380, 2), 1'b0);
    endtask

    task automatic t_mixed();
        logic [NP*DW-1:0] nd, od;
        for (int p = 0; p < NP; p++) begin
            nd[p*DW +: DW] = DW'(200 + ((p * 37) % 150));
            od[p*DW +: DW] = DW'((p % 2 == 0) ? 260 : 230 + p);
        end
        run_tile("R5 mixed", 200, 349, 220, 300, nd, od, 1'b0);
    endtask

    task automatic t_ties();
        run_tile("R5 ties", 100, 250, 100, 250, ramp(100, 10), ramp(100, 10), 1'b0);
    endtask

    task automatic t_busy();
        logic [NP*DW-1:0] nd, od;
        nd = ramp(300, 7);
        od = ramp(420, -5);
        run_tile("R9 busy", 300, 405, 345, 420, nd, od, 1'b1);
        @(negedge clk);
        chk("R10 pulse", 64'(out_valid), 64'd0);
        chk("R9 no stray", 64'(in_ready), 64'd1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        tile_zmin = 700; tile_zmax = 800; buf_zmin = 10; buf_zmax = 20; in_valid = 1'b1;
        @(negedge clk);
        chk("R1 b2b first", 64'(out_decision), 64'd0);
        tile_zmin = 1; tile_zmax = 2;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second valid", 64'(out_valid), 64'd1);
        chk("R2 b2b second dec", 64'(out_decision), 64'd1);
        @(negedge clk);
        chk("R10 hold dec", 64'(out_decision), 64'd1);
        chk("R10 hold zmin", 64'(out_zmin), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        tile_zmin = '0; tile_zmax = '0; buf_zmin = '0; buf_zmax = '0;
        new_depth = '0; old_depth = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_accept();
        t_priority();
        t_edge();
        t_mixed();
        t_ties();
        t_busy();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule